// File: doc/BRIEF.md
# LCD Blink Timer

This block paces the blinking of a low-multiplex segment LCD driver. From the display clock it derives a slow blink period. In each blink period it decides whether the readout path fetches segment data from the normal display RAM bank or from the alternate bank. The length of the period depends on a two-bit blink code and on a low-power flag. In the low-power mode the display clock runs slower, so the divide ratios are smaller.

Bank swapping only makes sense when a spare bank exists. That is the case in the static and 1:2 multiplex drives. In the 1:3 and 1:4 drives the timer still runs, but the readout stays on the normal bank. A separate enable input blanks the whole display without disturbing the timing. Each phase change is marked by a one-cycle strobe, so the blink period can be measured from outside.

Top module: `lcd_blink_timer`

## Requirements
- R1: With blink code 0 no blinking occurs. `bank_alt` and `blink_tick` stay 0, and the phase is held at the normal bank.
- R2: With the low-power flag clear, blink codes 1, 2 and 3 give a full blink period of NORM_BASE, 2·NORM_BASE and 4·NORM_BASE clock cycles. The defaults are 92160, 184320 and 368640. Each half of the period lasts half of that.
- R3: With the low-power flag set, the periods for codes 1, 2 and 3 are SAVE_BASE, 2·SAVE_BASE and 4·SAVE_BASE cycles. The defaults are 15360, 30720 and 61440.
- R4: Each period begins with the normal-bank half and ends with the alternate-bank half. After a restart on clock edge E0, the phase first toggles on edge E0 + half.
- R5: In multiplex modes 0 (static) and 1 (1:2), `bank_alt` follows the blink phase. It is 1 during the alternate half.
- R6: In multiplex modes 2 (1:3) and 3 (1:4), `bank_alt` stays 0 while the timer and `blink_tick` keep running.
- R7: `blank` is the inverse of `disp_en` in every state. `disp_en` has no effect on the timing or on `bank_alt`.
- R8: `blink_tick` is high for exactly one cycle after each phase toggle.
- R9: Any change of the blink code, the low-power flag or the multiplex mode restarts the divider on the next edge. The phase returns to normal, and no tick is given on that edge.
- R10: While `rst` is high, `bank_alt` and `blink_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst | input | 1 | Synchronous reset, active high |
| blink_sel | input | 2 | Blink code: 0 off, 1/2/3 fast/medium/slow |
| power_save | input | 1 | Low-power mode flag, selects the smaller divisors |
| mux_mode | input | 2 | Drive mode: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| disp_en | input | 1 | Display enable; 0 blanks the display |
| bank_alt | output | 1 | 1 selects the alternate RAM bank for readout |
| blank | output | 1 | 1 blanks the whole display |
| blink_tick | output | 1 | One-cycle pulse on each blink phase change |

## Verification
The hardest case to reach is a configuration change that lands in the middle of a running alternate half. There the counter holds a value that may exceed the new half length, and the phase is set. To reach it, the bench runs the slowest code past its first toggle and then switches to the fastest code on a chosen cycle. It then checks that the phase drops at once and that the next toggle arrives exactly one new half later. Small base divisors make it cheap to sweep every combination of code, flag, drive mode and enable. In each combination the bench checks three toggles cycle by cycle.

// File: rtl/lcd_blink_timer.sv
module lcd_blink_timer #(
  parameter int NORM_BASE = 92160,
  parameter int SAVE_BASE = 15360
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] blink_sel,
  input  logic       power_save,
  input  logic [1:0] mux_mode,
  input  logic       disp_en,
  output logic       bank_alt,
  output logic       blank,
  output logic       blink_tick
);
  localparam int TOP_BASE = (NORM_BASE > SAVE_BASE) ? NORM_BASE : SAVE_BASE;
  localparam int MAX_HALF = TOP_BASE * 2;
  localparam int CW = $clog2(MAX_HALF + 1);

  logic [CW-1:0] cnt, half_len, base_half;
  logic [4:0] cfg_q;
  logic phase;

  wire [4:0] cfg = {blink_sel, power_save, mux_mode};
  wire restart = (cfg != cfg_q);
  wire at_end = (cnt == half_len - CW'(1));

  assign base_half = power_save ? CW'(SAVE_BASE / 2) : CW'(NORM_BASE / 2);

  always_comb begin
    case (blink_sel)
      2'd1:    half_len = base_half;
      2'd2:    half_len = base_half << 1;
      2'd3:    half_len = base_half << 2;
      default: half_len = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      phase      <= 1'b0;
      blink_tick <= 1'b0;
      cfg_q      <= '0;
    end else begin
      cfg_q      <= cfg;
      blink_tick <= 1'b0;
      if (restart || blink_sel == 2'd0) begin
        cnt   <= '0;
        phase <= 1'b0;
      end else if (at_end) begin
        cnt        <= '0;
        phase      <= ~phase;
        blink_tick <= 1'b1;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign bank_alt = phase & ~mux_mode[1];
  assign blank    = ~disp_en;

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    (blink_sel == 2'd0) |=> (cnt == '0 && !phase && !blink_tick)); // R1
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (blink_sel != 2'd0 && !restart) |-> (cnt < half_len)); // R2
  AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    blink_tick |-> (phase != $past(phase))); // R8
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    blink_tick |=> !blink_tick); // R8
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0 && !phase && !blink_tick)); // R9
endmodule

// File: tb/lcd_blink_timer_test.sv
`timescale 1ns/1ps
module lcd_blink_timer_test;
  localparam int NB = 12;
  localparam int SB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] blink_sel = 2'd0;
  logic power_save = 1'b0;
  logic [1:0] mux_mode = 2'd0;
  logic disp_en = 1'b1;
  logic bank_alt, blank, blink_tick;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lcd_blink_timer #(.NORM_BASE(NB), .SAVE_BASE(SB)) uut (
    .clk(clk), .rst(rst), .blink_sel(blink_sel), .power_save(power_save),
    .mux_mode(mux_mode), .disp_en(disp_en), .bank_alt(bank_alt),
    .blank(blank), .blink_tick(blink_tick));

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  function automatic int half_of(input int code, input logic ps);
    int base = ps ? SB : NB;
    return (code == 0) ? 0 : (base / 2) << (code - 1);
  endfunction

  task automatic observe(input int code, input logic ps, input logic [1:0] mx,
                         input logic en, input int cycles);
    int h = half_of(code, ps);
    for (int j = 0; j < cycles; j++) begin
      logic ph, tk;
      @(posedge clk); @(negedge clk);
      ph = (h == 0) ? 1'b0 : 1'(((j / h) % 2));
      tk = (h != 0) && (j > 0) && (j % h == 0);
      if (code == 0) begin
        chk(blink_tick, 1'b0, "R1 tick");
        chk(bank_alt, 1'b0, "R1 bank");
      end else begin
        chk(blink_tick, tk, ps ? "R3 R8 tick" : "R2 R8 tick");
        if (mx[1]) chk(bank_alt, 1'b0, "R6 bank");
        else chk(bank_alt, ph, "R4 R5 bank");
      end
      chk(blank, ~en, "R7 blank");
    end
  endtask

  task automatic run_cfg(input int code, input logic ps, input logic [1:0] mx,
                         input logic en);
    @(negedge clk);
    blink_sel = 2'd0; power_save = ps; mux_mode = mx; disp_en = en;
    @(posedge clk); @(negedge clk);
    blink_sel = 2'(code);
    observe(code, ps, mx, en, (code == 0) ? 20 : 3 * half_of(code, ps) + 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bank_alt, 1'b0, "R10 bank");
    chk(blink_tick, 1'b0, "R10 tick");
    rst = 1'b0;
    for (int m = 0; m < 4; m++)
      for (int p = 0; p < 2; p++)
        for (int c = 0; c < 4; c++)
          for (int e = 0; e < 2; e++)
            run_cfg(c, 1'(p), 2'(m), 1'(e));
    // R9: change code in the middle of the alternate half
    run_cfg(3, 1'b0, 2'd0, 1'b1);
    observe(3, 1'b0, 2'd0, 1'b1, 0);
    @(negedge clk);
    blink_sel = 2'd3;
    @(posedge clk); @(negedge clk);
    blink_sel = 2'd0;
    @(posedge clk); @(negedge clk);
    blink_sel = 2'd3;
    observe(3, 1'b0, 2'd0, 1'b1, 27);
    chk(bank_alt, 1'b1, "R9 pre-change phase");
    blink_sel = 2'd1;
    observe(1, 1'b0, 2'd0, 1'b1, 13);
    // R9: flip power_save while running
    @(negedge clk);
    power_save = 1'b1;
    observe(1, 1'b1, 2'd0, 1'b1, 9);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule